// File: doc/BRIEF.md
# Synchronous Tag Store with Match Comparator

This block is a small synchronous tag memory with a comparator built in. Each word is 18 bits wide, made of two 9-bit lanes. All commands are sampled on the rising clock edge. A cycle can write the whole word, write selected lanes, read a word, or run a compare. A compare is a read that keeps the data drivers off. On a compare, the key on the data input is registered and checked against the stored word at the registered address. The result is a match flag.

A static mode input selects the output timing. In flow-through mode, results leave the array straight through, one edge after the command. In pipelined mode, one more register stage follows, so results appear two edges after the command. The same stage carries the data, the drive flag and the match flag. Deselect and write cycles travel down the same path as reads. In pipelined mode, the drivers therefore stay on for one full cycle after a deselect is sampled, and they switch off after the following edge. Two asynchronous enables gate the data drivers and the match output.

Top module: `tag_cmp_top`

## Requirements
- R1: While reset is high and after it is released, with no command issued, `dout_on` is 0 and `match` is 0 in both modes.
- R2: A selected cycle with `gwr`=1 writes all 18 bits at `addr`, whatever the values of `bwe` and `bstb`.
- R3: With `gwr`=0 and `bwe`=1, `bstb[0]` writes bits 8:0 and `bstb[1]` writes bits 17:9. A lane whose strobe is 0 keeps its old value. If `bwe`=1 and `bstb`=0, the cycle is a plain read.
- R4: A read sampled at edge N drives its word on `dout` with `dout_on`=1. In flow-through mode (`flow`=1) this happens after edge N. In pipelined mode (`flow`=0) it happens after edge N+1.
- R5: Back-to-back reads deliver one word per clock cycle in either mode.
- R6: A compare (`sel`=1, `cmp`=1, no write) raises `match` when the registered `din` equals the stored word, and leaves it 0 otherwise. Its latency is the same as a read. `dout_on` is 0 for a compare result.
- R7: `match` is 0 in every output cycle that does not belong to a compare.
- R8: A deselect (`sel`=0) passes through the same stages as a read. In pipelined mode, the outputs of the previous read stay driven for one cycle after the deselect is sampled, and they turn off after the next edge.
- R9: `oe`=0 forces `dout_on`=0 and `dout`=0 at once, with no clock edge. `moe`=0 forces `match`=0 at once.
- R10: A read issued on the cycle after a write to the same address returns the new data.
- R11: A write cycle with `cmp`=1 writes normally. Its output slot is not driven and shows no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output stages |
| flow | input | 1 | 1 = flow-through timing, 0 = pipelined timing |
| sel | input | 1 | Select; 0 issues a deselect |
| gwr | input | 1 | Whole-word write |
| bwe | input | 1 | Lane-write enable |
| bstb | input | 2 | Per-lane write strobes |
| cmp | input | 1 | Compare cycle request |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| din | input | 18 | Write data or compare key |
| oe | input | 1 | Asynchronous data output enable |
| moe | input | 1 | Asynchronous match output enable |
| dout | output | 18 | Read data, 0 when not driven |
| dout_on | output | 1 | Data drivers active |
| match | output | 1 | Compare result |

## Verification
The hardest case to reach from the ports is the dual-cycle deselect window in pipelined mode. The drivers must stay on in the cycle after a deselect has been sampled, and a wrong design that switches them off one edge early looks correct under isolated reads. The stimulus interleaves single deselects between reads and pairs of deselects after reads. A cycle-by-cycle model then predicts the drive flag from the command two edges back. The asynchronous enables are toggled between clock edges, while a read or a matching compare is being presented, to check their immediate effect.

// File: rtl/tag_cmp_pkg.sv
package tag_cmp_pkg;

    localparam int WORD_W = 18;
    localparam int LANE_W = 9;
    localparam int LANES  = WORD_W / LANE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_MATCH = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [WORD_W-1:0] key;
    } slot_t;

    function automatic op_e classify(input logic sel, input logic gwr,
                                     input logic bwe, input logic [LANES-1:0] bstb,
                                     input logic cmp);
        if (!sel)                         return OP_IDLE;
        else if (gwr || (bwe && |bstb))   return OP_WRITE;
        else if (cmp)                     return OP_MATCH;
        else                              return OP_READ;
    endfunction

    function automatic logic [WORD_W-1:0] lane_bits(input logic [LANES-1:0] en);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < LANES; i++)
            m[i*LANE_W +: LANE_W] = {LANE_W{en[i]}};
        return m;
    endfunction

endpackage

// File: rtl/tag_cmp_decode.sv
module tag_cmp_decode
    import tag_cmp_pkg::*;
(
    input  logic             sel,
    input  logic             gwr,
    input  logic             bwe,
    input  logic [LANES-1:0] bstb,
    input  logic             cmp,
    output op_e              op,
    output logic [WORD_W-1:0] wmask
);
    always_comb begin
        op = classify(sel, gwr, bwe, bstb, cmp);
        if (gwr)
            wmask = '1;
        else if (bwe)
            wmask = lane_bits(bstb);
        else
            wmask = '0;
    end
endmodule

// File: rtl/tag_cmp_array.sv
module tag_cmp_array
    import tag_cmp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wmask,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] old_word;

    assign old_word = mem[waddr];
    assign rdata    = mem[raddr];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= (old_word & ~wmask) | (wdata & wmask);
    end

    // R2: a full-mask write leaves exactly the written word
    a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
        (we && wmask == '1) |=> mem[$past(waddr)] == $past(wdata));

    // R3: an unstrobed low lane keeps its previous contents
    a_r3_lane_kept: assert property (@(posedge clk) disable iff (rst)
        (we && !wmask[0]) |=> mem[$past(waddr)][LANE_W-1:0] == $past(old_word[LANE_W-1:0]));
endmodule

// File: rtl/tag_cmp_outstage.sv
module tag_cmp_outstage
    import tag_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flow,
    input  slot_t             s1,
    input  logic [WORD_W-1:0] rdata,
    input  logic              oe,
    input  logic              moe,
    output logic [WORD_W-1:0] dout,
    output logic              dout_on,
    output logic              match
);
    logic              drv_f, hit_f;
    logic              drv_p, hit_p;
    logic [WORD_W-1:0] dat_p;
    logic              drv_s, hit_s;
    logic [WORD_W-1:0] dat_s;

    assign drv_f = (s1.op == OP_READ);
    assign hit_f = (s1.op == OP_MATCH) && (rdata == s1.key);

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_p <= 1'b0;
            hit_p <= 1'b0;
            dat_p <= '0;
        end else begin
            drv_p <= drv_f;
            hit_p <= hit_f;
            dat_p <= rdata;
        end
    end

    always_comb begin
        if (flow) begin
            drv_s = drv_f;
            hit_s = hit_f;
            dat_s = rdata;
        end else begin
            drv_s = drv_p;
            hit_s = hit_p;
            dat_s = dat_p;
        end
    end

    assign dout_on = oe & drv_s;
    assign dout    = dout_on ? dat_s : '0;
    assign match   = moe & hit_s;

    // R7: in steady pipelined mode a match must come from a compare one edge back
    a_r7_match_needs_cmp: assert property (@(posedge clk) disable iff (rst)
        (!flow && $past(!flow) && match) |-> $past(s1.op == OP_MATCH));

    // R6: a compare in the flow-through slot never drives data
    a_r6_cmp_silent: assert property (@(posedge clk) disable iff (rst)
        (flow && s1.op == OP_MATCH) |-> !dout_on);

    always_comb begin
        if (!oe) a_r9_oe_gate: assert (!dout_on && dout == '0);
        if (!moe) a_r9_moe_gate: assert (!match);
    end
endmodule

// File: rtl/tag_cmp_top.sv
module tag_cmp_top
    import tag_cmp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flow,
    input  logic              sel,
    input  logic              gwr,
    input  logic              bwe,
    input  logic [LANES-1:0]  bstb,
    input  logic              cmp,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] din,
    input  logic              oe,
    input  logic              moe,
    output logic [WORD_W-1:0] dout,
    output logic              dout_on,
    output logic              match
);
    op_e               op_in;
    logic [WORD_W-1:0] wmask;
    slot_t             s1;
    logic [AW-1:0]     s1_addr;
    logic [WORD_W-1:0] rdata;

    tag_cmp_decode u_dec (
        .sel  (sel),
        .gwr  (gwr),
        .bwe  (bwe),
        .bstb (bstb),
        .cmp  (cmp),
        .op   (op_in),
        .wmask(wmask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1.op   <= OP_IDLE;
            s1.key  <= '0;
            s1_addr <= '0;
        end else begin
            s1.op   <= op_in;
            s1.key  <= din;
            s1_addr <= addr;
        end
    end

    tag_cmp_array #(.DEPTH(DEPTH)) u_arr (
        .clk  (clk),
        .rst  (rst),
        .we   (op_in == OP_WRITE),
        .wmask(wmask),
        .waddr(addr),
        .wdata(din),
        .raddr(s1_addr),
        .rdata(rdata)
    );

    tag_cmp_outstage u_out (
        .clk    (clk),
        .rst    (rst),
        .flow   (flow),
        .s1     (s1),
        .rdata  (rdata),
        .oe     (oe),
        .moe    (moe),
        .dout   (dout),
        .dout_on(dout_on),
        .match  (match)
    );

    // R8: in steady pipelined mode a deselect two edges back leaves the drivers off
    a_r8_desel_off: assert property (@(posedge clk) disable iff (rst)
        (!flow && $past(!flow) && $past(!flow, 2) && $past(!sel, 2)) |-> !dout_on);
endmodule

// File: tb/sim_tag_cmp_top.sv
`timescale 1ns/1ps
module sim_tag_cmp_top;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic        clk = 1'b0;
    logic        rst, flow, sel, gwr, bwe, cmp, oe, moe;
    logic [1:0]  bstb;
    logic [AW-1:0] addr;
    logic [17:0] din, dout;
    logic        dout_on, match;

    always #4 clk = ~clk;

    tag_cmp_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .flow(flow), .sel(sel), .gwr(gwr), .bwe(bwe),
        .bstb(bstb), .cmp(cmp), .addr(addr), .din(din), .oe(oe), .moe(moe),
        .dout(dout), .dout_on(dout_on), .match(match)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    bit chk_on = 0;

    logic [17:0] shadow [DEPTH];
    // op codes in the model: 0 idle, 1 read, 2 compare, 3 write
    int          p_op = 0, c_op = 0;
    logic [17:0] p_dat = '0, c_dat = '0, p_key = '0, c_key = '0;
    string       p_tg = "R1", c_tg = "R1";

    task automatic chk(input string tg, input string what,
                       input logic [17:0] got, input logic [17:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", tg, what, got, exp, $time);
        end
    endtask

    task automatic issue(input string tg, input bit s, input bit g, input bit b,
                         input logic [1:0] st, input bit c, input int a,
                         input logic [17:0] d);
        int          op;
        logic [17:0] m;
        logic [17:0] edat, ekey;
        int          eop;
        string       etg;
        sel = s; gwr = g; bwe = b; bstb = st; cmp = c; addr = AW'(a); din = d;
        if (!s)                     op = 0;
        else if (g || (b && |st))   op = 3;
        else if (c)                 op = 2;
        else                        op = 1;
        p_op = c_op; p_dat = c_dat; p_key = c_key; p_tg = c_tg;
        c_op = op; c_dat = shadow[a]; c_key = d; c_tg = tg;
        if (op == 3) begin
            m = g ? 18'h3ffff : {{9{st[1]}}, {9{st[0]}}};
            shadow[a] = (shadow[a] & ~m) | (d & m);
        end
        @(posedge clk);
        @(negedge clk);
        if (chk_on) begin
            if (flow) begin eop = c_op; edat = c_dat; ekey = c_key; etg = c_tg; end
            else      begin eop = p_op; edat = p_dat; ekey = p_key; etg = p_tg; end
            chk(etg, "dout_on", {17'd0, dout_on}, {17'd0, eop == 1});
            chk(etg, "dout", dout, (eop == 1) ? edat : 18'd0);
            chk((eop == 2) ? etg : "R7", "match", {17'd0, match},
                {17'd0, (eop == 2) && (edat == ekey)});
        end
    endtask

    task automatic idle(input string tg);
        issue(tg, 0, 0, 0, 2'b00, 0, 0, 18'd0);
    endtask

    task automatic rd(input string tg, input int a);
        issue(tg, 1, 0, 0, 2'b00, 0, a, 18'd0);
    endtask

    task automatic set_mode(input bit m);
        chk_on = 0;
        flow = m;
        repeat (3) idle("R8");
        chk_on = 1;
    endtask

    function automatic logic [17:0] pat(input int a, input int m);
        return 18'((a * 18'h2b5 + m * 18'h1357) ^ 18'h2aaaa);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; flow = 0; sel = 0; gwr = 0; bwe = 0; bstb = 0; cmp = 0;
        addr = '0; din = '0; oe = 1; moe = 1;
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1", "dout_on in reset", {17'd0, dout_on}, 18'd0);
        chk("R1", "match in reset", {17'd0, match}, 18'd0);
        rst = 0;
        @(negedge clk);
        chk("R1", "dout_on after reset", {17'd0, dout_on}, 18'd0);
        chk("R1", "match after reset", {17'd0, match}, 18'd0);

        for (int m = 1; m >= 0; m--) begin
            set_mode(m[0]);
            // R2: global write sweep, lane controls set to conflicting values
            for (int a = 0; a < DEPTH; a++)
                issue("R2", 1, 1, a[0], a[0] ? 2'b01 : 2'b00, 0, a, pat(a, m));
            // R5 / R2: back-to-back read sweep
            for (int a = 0; a < DEPTH; a++) rd("R5", a);
            // R4: isolated read after idles exposes the latency
            idle("R8"); idle("R8");
            rd("R4", 3);
            idle("R4"); idle("R8");
            // R3: every strobe combination on every address, then read back
            for (int a = 0; a < DEPTH; a++)
                for (int st = 0; st < 4; st++) begin
                    issue("R3", 1, 0, 1, 2'(st), 0, a, ~pat(a + st, m));
                    rd("R3", a);
                end
            // R10: write then immediate read of the same address
            for (int a = 0; a < DEPTH; a += 3) begin
                issue("R10", 1, 1, 0, 2'b00, 0, a, pat(a + 7, m));
                rd("R10", a);
            end
            // R8: single and double deselects between reads
            for (int a = 0; a < 6; a++) begin
                rd("R8", a);
                idle("R8");
                rd("R8", a + 1);
                idle("R8");
                idle("R8");
            end
            // R6: compare each address with its own word and with a one-bit change
            for (int a = 0; a < DEPTH; a++) begin
                issue("R6", 1, 0, 0, 2'b00, 1, a, shadow[a]);
                issue("R6", 1, 0, 0, 2'b00, 1, a, shadow[a] ^ (18'd1 << (a % 18)));
                rd("R6", a);
            end
            // R11: write with compare request, then read and compare
            issue("R11", 1, 1, 0, 2'b00, 1, 5, pat(99, m));
            rd("R11", 5);
            issue("R11", 1, 0, 0, 2'b00, 1, 5, pat(99, m));
            idle("R11"); idle("R11");
            // R9: asynchronous enables while a read result is presented
            rd("R9", 2); rd("R9", 2);
            oe = 0; #1;
            chk("R9", "dout_on oe low", {17'd0, dout_on}, 18'd0);
            chk("R9", "dout oe low", dout, 18'd0);
            oe = 1; #1;
            chk("R9", "dout oe back", dout, shadow[2]);
            issue("R9", 1, 0, 0, 2'b00, 1, 4, shadow[4]);
            issue("R9", 1, 0, 0, 2'b00, 1, 4, shadow[4]);
            moe = 0; #1;
            chk("R9", "match moe low", {17'd0, match}, 18'd0);
            moe = 1; #1;
            chk("R9", "match moe back", {17'd0, match}, 18'd1);
            idle("R8"); idle("R8");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule